// File: doc/BRIEF.md
# Error-Compensated Truncating Adder Tree

This block adds a set of shifted signed partial words in one pass, the way a distributed-arithmetic inner product needs them added. Word `k` of the input bus carries weight 2^k. Every word is aligned and reduced at the same time: carry-save levels of 3:2 compressors bring the rows down to two, and one carry-propagate adder then produces the total. The shift-and-add is fully unrolled, so nothing is accumulated one bit per cycle. A new set of words can be accepted on every clock.

The result is narrower than the full sum. The lowest `CUT` bit positions are dropped, and the mode parameter decides how that is done. In the exact mode the full-width sum is formed and then rounded. In the direct mode the low region of every aligned word is thrown away before the addition. The compensated mode works like the direct mode but adds a constant bias. That bias is the rounded mean carry that the discarded region would have delivered. The compensated mode has nearly the cost of the direct mode and much less systematic error. The default word width is 9 bits.

Top module: `comp_trunc_tree`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `valid_o` = 0 and `sum_o` = 0.
- R2: A set of words accepted with `valid_i` high produces exactly one result with `valid_o` high, `PIPE`+1 cycles later. Results come out in input order, and back-to-back inputs are accepted.
- R3: Word `k` occupies bits `[k*W_WORD +: W_WORD]` of `words_i`. It is read as two's complement and carries weight 2^k.
- R4: With `MODE` = exact, `sum_o` = floor((S + 2^(CUT-1)) / 2^CUT), where S = sum of x_k*2^k.
- R5: With `MODE` = direct, `sum_o` = sum over k of floor(x_k*2^k / 2^CUT).
- R6: With `MODE` = compensated, `sum_o` equals the direct-mode value plus `COMP_BIAS`. The default bias is floor(E + 1/2), where E = sum over k < CUT of (1 - 2^(k-CUT))/2. For 8 words and CUT = 6 this gives 3.
- R7: Over uniformly random words, the mean error of the compensated result against S/2^CUT is smaller in magnitude than the mean error of the direct result.
- R8: While `valid_i` is low, changes on `words_i` have no effect. `sum_o` keeps its last result and `valid_o` stays low once the pipeline has drained.
- R9: Words at the extremes of their range (all at the most negative value, all at the most positive value, mixed signs) give the values of R4 to R6 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| words_i | input | N_WORDS*W_WORD | Packed signed partial words; word k has weight 2^k |
| valid_i | input | 1 | Words on `words_i` are to be summed |
| valid_o | output | 1 | `sum_o` holds a new result this cycle |
| sum_o | output | W_SUM-CUT | Signed sum with the low `CUT` bit positions removed |

## Verification
The bench runs three instances side by side, one per mode, on the same stimulus. It uses one-hot words to catch a shift that is off by one position, and all-minimum and all-maximum words to catch sign extension or guard-bit errors, which would show up as wrapped results. Negative words with nonzero low bits catch a design that truncates toward zero where flooring is required: such a design would be off by one in the direct mode. A wrong bias value or a missing bias row would show as a constant offset between the compensated and direct outputs, and as a larger mean error over a random run. The bench also measures the latency of a single isolated input and toggles the words while `valid_i` is low, to catch a pipeline stage that is too short or too long and an output register that loads without a valid input.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

  typedef enum logic [1:0] {
    SUM_EXACT  = 2'd0,
    SUM_DIRECT = 2'd1,
    SUM_COMP   = 2'd2
  } sum_mode_e;

  // rows left after a number of 3:2 levels
  function automatic int rows_after(int rows, int levels);
    int r;
    r = rows;
    for (int l = 0; l < levels; l++) r = 2 * (r / 3) + (r % 3);
    return r;
  endfunction

  // 3:2 levels needed to bring a row count down to two
  function automatic int level_count(int rows);
    int r;
    int n;
    r = rows;
    n = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      n++;
    end
    return n;
  endfunction

  // rounded mean carry of the discarded region, word k shifted by k
  function automatic int mean_carry_bias(int n_words, int cut);
    int acc;
    acc = 0;
    for (int k = 0; k < n_words; k++)
      if (k < cut) acc += (2 ** cut) - (2 ** k);
    return (acc + (2 ** cut)) / (2 ** (cut + 1));
  endfunction

endpackage

// File: rtl/ctt_align.sv
module ctt_align #(
  parameter int                 W_WORD = 9,
  parameter int                 W_SUM  = 18,
  parameter int                 SHIFT  = 0,
  parameter int                 CUT    = 6,
  parameter ctt_pkg::sum_mode_e MODE   = ctt_pkg::SUM_COMP
) (
  input  logic [W_WORD-1:0] word_i,
  output logic [W_SUM-1:0]  row_o
);
  localparam logic [W_SUM-1:0] KEEP_MASK = ~((W_SUM'(1) << CUT) - W_SUM'(1));

  logic [W_SUM-1:0] wide;
  logic [W_SUM-1:0] shifted;

  assign wide    = {{(W_SUM - W_WORD){word_i[W_WORD-1]}}, word_i};
  assign shifted = wide << SHIFT;

  generate
    if (MODE == ctt_pkg::SUM_EXACT) begin : g_full
      assign row_o = shifted;
    end else begin : g_cut
      assign row_o = shifted & KEEP_MASK;
    end
  endgenerate
endmodule

// File: rtl/ctt_csa32.sv
module ctt_csa32 #(
  parameter int W = 18
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  assign carry_o[0] = 1'b0;
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign sum_o[b] = a_i[b] ^ b_i[b] ^ c_i[b];
      if (b < W - 1) begin : g_cy
        assign carry_o[b+1] = (a_i[b] & b_i[b]) | (a_i[b] & c_i[b]) | (b_i[b] & c_i[b]);
      end
    end
  endgenerate
endmodule

// File: rtl/ctt_csa_tree.sv
module ctt_csa_tree #(
  parameter int W    = 18,
  parameter int ROWS = 9
) (
  input  logic [W-1:0] rows_i [ROWS],
  output logic [W-1:0] vec_a_o,
  output logic [W-1:0] vec_b_o
);
  localparam int NLEV = ctt_pkg::level_count(ROWS);

  logic [W-1:0] lvl [NLEV+1][ROWS];

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_in
      assign lvl[0][r] = rows_i[r];
    end

    for (genvar lv = 0; lv < NLEV; lv++) begin : g_lvl
      localparam int RIN  = ctt_pkg::rows_after(ROWS, lv);
      localparam int NG   = RIN / 3;
      localparam int REM  = RIN % 3;
      localparam int ROUT = 2 * NG + REM;
      for (genvar g = 0; g < NG; g++) begin : g_grp
        ctt_csa32 #(.W(W)) u_csa (
          .a_i    (lvl[lv][3*g]),
          .b_i    (lvl[lv][3*g+1]),
          .c_i    (lvl[lv][3*g+2]),
          .sum_o  (lvl[lv+1][2*g]),
          .carry_o(lvl[lv+1][2*g+1])
        );
      end
      for (genvar r = 0; r < REM; r++) begin : g_pass
        assign lvl[lv+1][2*NG+r] = lvl[lv][3*NG+r];
      end
      for (genvar r = ROUT; r < ROWS; r++) begin : g_zero
        assign lvl[lv+1][r] = '0;
      end
    end
  endgenerate

  assign vec_a_o = lvl[NLEV][0];
  assign vec_b_o = (ROWS > 1) ? lvl[NLEV][ROWS > 1 ? 1 : 0] : '0;
endmodule

// File: rtl/ctt_cpa.sv
module ctt_cpa #(
  parameter int W = 18
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/comp_trunc_tree.sv
module comp_trunc_tree #(
  parameter int                 N_WORDS   = 8,
  parameter int                 W_WORD    = 9,
  parameter int                 CUT       = 6,
  parameter int                 PIPE      = 1,
  parameter ctt_pkg::sum_mode_e MODE      = ctt_pkg::SUM_COMP,
  parameter int                 COMP_BIAS = ctt_pkg::mean_carry_bias(N_WORDS, CUT),
  localparam int                W_SUM     = W_WORD + N_WORDS + 1,
  localparam int                W_OUT     = W_SUM - CUT
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_WORDS*W_WORD-1:0]   words_i,
  input  logic                        valid_i,
  output logic                        valid_o,
  output logic signed [W_OUT-1:0]     sum_o
);
  localparam int ROWS = N_WORDS + 1;

  logic [W_SUM-1:0]        rows0 [ROWS];
  logic [W_SUM-1:0]        vec_a, vec_b;
  logic [W_SUM-1:0]        st_a, st_b;
  logic                    st_vld;
  logic [W_SUM-1:0]        total_u;
  logic signed [W_SUM-1:0] total;

  generate
    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      ctt_align #(
        .W_WORD(W_WORD), .W_SUM(W_SUM), .SHIFT(k), .CUT(CUT), .MODE(MODE)
      ) u_align (
        .word_i(words_i[k*W_WORD +: W_WORD]),
        .row_o (rows0[k])
      );
    end

    if (MODE == ctt_pkg::SUM_EXACT) begin : g_round_row
      assign rows0[N_WORDS] = W_SUM'(1) << (CUT - 1);
    end else if (MODE == ctt_pkg::SUM_COMP) begin : g_bias_row
      assign rows0[N_WORDS] = W_SUM'(COMP_BIAS) << CUT;
    end else begin : g_no_row
      assign rows0[N_WORDS] = '0;
    end
  endgenerate

  ctt_csa_tree #(.W(W_SUM), .ROWS(ROWS)) u_tree (
    .rows_i (rows0),
    .vec_a_o(vec_a),
    .vec_b_o(vec_b)
  );

  generate
    if (PIPE != 0) begin : g_pipe
      always_ff @(posedge clk) begin
        if (rst) st_vld <= 1'b0;
        else     st_vld <= valid_i;
        st_a <= vec_a;
        st_b <= vec_b;
      end
    end else begin : g_flow
      assign st_vld = valid_i;
      assign st_a   = vec_a;
      assign st_b   = vec_b;
    end
  endgenerate

  ctt_cpa #(.W(W_SUM)) u_cpa (
    .a_i  (st_a),
    .b_i  (st_b),
    .sum_o(total_u)
  );

  assign total = total_u;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= st_vld;
      if (st_vld) sum_o <= W_OUT'(total >>> CUT);
    end
  end
endmodule

// File: rtl/ctt_chk.sv
module ctt_chk #(
  parameter int                 N_WORDS   = 8,
  parameter int                 W_WORD    = 9,
  parameter int                 CUT       = 6,
  parameter int                 PIPE      = 1,
  parameter ctt_pkg::sum_mode_e MODE      = ctt_pkg::SUM_COMP,
  parameter int                 COMP_BIAS = 3,
  parameter int                 W_SUM     = 18,
  parameter int                 W_OUT     = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_WORDS*W_WORD-1:0] words_i,
  input logic                      valid_i,
  input logic                      valid_o,
  input logic signed [W_OUT-1:0]   sum_o
);
  localparam int LAT   = PIPE + 1;
  localparam int LOSSY = (N_WORDS < CUT) ? N_WORDS : CUT;
  localparam logic signed [W_SUM-1:0] HALF = W_SUM'(1) << (CUT - 1);

  logic signed [W_SUM-1:0] full_ref;
  logic signed [W_OUT-1:0] round_ref;
  logic                    vq [LAT];
  logic signed [W_OUT-1:0] rq [LAT];
  int                      diff;

  always_comb begin
    logic signed [W_WORD-1:0] wv;
    full_ref = '0;
    for (int k = 0; k < N_WORDS; k++) begin
      wv       = words_i[k*W_WORD +: W_WORD];
      full_ref = full_ref + (W_SUM'(wv) <<< k);
    end
    round_ref = W_OUT'((full_ref + HALF) >>> CUT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) vq[i] <= 1'b0;
    end else begin
      vq[0] <= valid_i;
      for (int i = 1; i < LAT; i++) vq[i] <= vq[i-1];
    end
    rq[0] <= round_ref;
    for (int i = 1; i < LAT; i++) rq[i] <= rq[i-1];
  end

  assign diff = int'(sum_o) - int'(rq[LAT-1]);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!valid_o && sum_o == '0));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    valid_o == vq[LAT-1]);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(sum_o));

  generate
    if (MODE == ctt_pkg::SUM_EXACT) begin : g_exact
      a_r4_exact_round: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> diff == 0);
    end else if (MODE == ctt_pkg::SUM_DIRECT) begin : g_direct
      a_r5_direct_below: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (diff <= 0 && diff >= -LOSSY - 1));
    end else begin : g_comp
      a_r6_comp_window: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (diff <= COMP_BIAS && diff >= COMP_BIAS - LOSSY - 1));
    end
  endgenerate
endmodule

bind comp_trunc_tree ctt_chk #(
  .N_WORDS(N_WORDS), .W_WORD(W_WORD), .CUT(CUT), .PIPE(PIPE), .MODE(MODE),
  .COMP_BIAS(COMP_BIAS), .W_SUM(W_SUM), .W_OUT(W_OUT)
) u_chk (
  .clk(clk), .rst(rst), .words_i(words_i), .valid_i(valid_i),
  .valid_o(valid_o), .sum_o(sum_o)
);

// File: tb/comp_trunc_tree_tb_top.sv
module comp_trunc_tree_tb_top;
  localparam int NW    = 8;
  localparam int WW    = 9;
  localparam int CUT   = 6;
  localparam int LAT   = 2;
  localparam int WOUT  = WW + NW + 1 - CUT;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [NW*WW-1:0]        words = '0;
  logic                    valid = 1'b0;
  logic                    vld_c, vld_x, vld_d;
  logic signed [WOUT-1:0]  sum_c, sum_x, sum_d;

  typedef struct {
    int    ex;
    int    dr;
    int    cp;
    real   ref_v;
    string tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  int   bias_m;
  real  acc_d = 0.0;
  real  acc_c = 0.0;
  int   n_stat = 0;

  always #2.5 clk = ~clk;

  comp_trunc_tree #(.N_WORDS(NW), .W_WORD(WW), .CUT(CUT), .PIPE(1),
                    .MODE(ctt_pkg::SUM_COMP)) dut_i (
    .clk(clk), .rst(rst), .words_i(words), .valid_i(valid),
    .valid_o(vld_c), .sum_o(sum_c));

  comp_trunc_tree #(.N_WORDS(NW), .W_WORD(WW), .CUT(CUT), .PIPE(1),
                    .MODE(ctt_pkg::SUM_EXACT)) dut_exact_i (
    .clk(clk), .rst(rst), .words_i(words), .valid_i(valid),
    .valid_o(vld_x), .sum_o(sum_x));

  comp_trunc_tree #(.N_WORDS(NW), .W_WORD(WW), .CUT(CUT), .PIPE(1),
                    .MODE(ctt_pkg::SUM_DIRECT)) dut_direct_i (
    .clk(clk), .rst(rst), .words_i(words), .valid_i(valid),
    .valid_o(vld_d), .sum_o(sum_d));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: one set of words, expectations into the scoreboard
  task automatic drive_vec(input int xs [NW], input string tag);
    exp_t e;
    int   s;
    int   dsum;
    @(negedge clk);
    s    = 0;
    dsum = 0;
    for (int k = 0; k < NW; k++) begin
      words[k*WW +: WW] = xs[k][WW-1:0];
      s    += xs[k] * (2 ** k);
      dsum += (xs[k] * (2 ** k)) >>> CUT;
    end
    valid   = 1'b1;
    e.ex    = (s + (2 ** (CUT - 1))) >>> CUT;
    e.dr    = dsum;
    e.cp    = dsum + bias_m;
    e.ref_v = real'(s) / real'(2 ** CUT);
    e.tag   = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && (vld_c || vld_x || vld_d)) begin
      chk(vld_c == vld_x && vld_c == vld_d, "R2", "valid agreement across modes",
          int'(vld_c), int'(vld_x));
      if (q.size() == 0) begin
        chk(1'b0, "R2", "result without pending input", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(sum_x) == e.ex, "R4", {"exact sum ", e.tag}, int'(sum_x), e.ex);
        chk(int'(sum_d) == e.dr, "R5", {"direct sum ", e.tag}, int'(sum_d), e.dr);
        chk(int'(sum_c) == e.cp, "R6", {"compensated sum ", e.tag}, int'(sum_c), e.cp);
        if (e.tag == "rand") begin
          acc_d += real'(sum_d) - e.ref_v;
          acc_c += real'(sum_c) - e.ref_v;
          n_stat++;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    int  xs [NW];
    int  lat;
    int  held;
    real m;
    real md, mc;

    m = 0.0;
    for (int k = 0; k < NW; k++)
      if (k < CUT) m += (1.0 - 2.0 ** (k - CUT)) / 2.0;
    bias_m = int'($floor(m + 0.5));

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(!vld_c && !vld_x && !vld_d, "R1", "valid low in reset", int'(vld_c), 0);
    chk(sum_c == 0 && sum_x == 0 && sum_d == 0, "R1", "sum zero in reset",
        int'(sum_c), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R2: latency of an isolated input
    for (int k = 0; k < NW; k++) xs[k] = 1;
    drive_vec(xs, "R2 single");
    lat = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      valid = 1'b0;
      lat++;
      if (vld_c) break;
    end
    chk(lat == LAT, "R2", "latency in cycles", lat, LAT);
    idle(3);

    // R3: one-hot words check alignment
    for (int j = 0; j < NW; j++) begin
      for (int k = 0; k < NW; k++) xs[k] = (k == j) ? 100 : 0;
      drive_vec(xs, "R3 onehot");
    end
    for (int j = 0; j < NW; j++) begin
      for (int k = 0; k < NW; k++) xs[k] = (k == j) ? -77 : 0;
      drive_vec(xs, "R3 onehot neg");
    end

    // R9: extremes and sign mixes
    for (int k = 0; k < NW; k++) xs[k] = -256;
    drive_vec(xs, "R9 all min");
    for (int k = 0; k < NW; k++) xs[k] = 255;
    drive_vec(xs, "R9 all max");
    for (int k = 0; k < NW; k++) xs[k] = (k % 2 == 0) ? 255 : -256;
    drive_vec(xs, "R9 alternate");
    for (int k = 0; k < NW; k++) xs[k] = -1;
    drive_vec(xs, "R9 all minus one");
    for (int k = 0; k < NW; k++) xs[k] = 0;
    drive_vec(xs, "R9 zero");
    idle(LAT + 2);
    chk(q.size() == 0, "R2", "all results delivered", q.size(), 0);

    // R8: words change while valid is low
    for (int k = 0; k < NW; k++) xs[k] = 37 * (k + 1) - 150;
    drive_vec(xs, "R8 last");
    idle(LAT + 2);
    held = int'(sum_c);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      words = {NW{9'h15A}} ^ {NW*WW{i[0]}};
      chk(!vld_c && int'(sum_c) == held, "R8", "output held while idle",
          int'(sum_c), held);
    end

    // R7: random stream with gaps
    for (int n = 0; n < 600; n++) begin
      for (int k = 0; k < NW; k++) xs[k] = int'($urandom_range(511, 0)) - 256;
      drive_vec(xs, "rand");
      if (n % 7 == 6) idle(1);
    end
    idle(LAT + 3);
    chk(q.size() == 0, "R2", "random stream drained", q.size(), 0);

    md = acc_d / real'(n_stat);
    mc = acc_c / real'(n_stat);
    $display("mean error: direct=%f compensated=%f", md, mc);
    chk((mc < 0 ? -mc : mc) < (md < 0 ? -md : md), "R7",
        "compensated mean error (x1000) below direct",
        int'(mc * 1000.0), int'(md * 1000.0));
    summary();
  end
endmodule